// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Limiter

This block sits between a PWM generator and the gate driver of a switching power stage. It passes the raw on-request through to the drive output, but it cuts the pulse short when a digital overcurrent flag is asserted. It also withholds whole switching periods while a fault persists. Each period begins with a one-cycle strobe. On a conducted period the comparator flag is ignored for a programmable blanking window, so that turn-on ringing cannot trip it. At the end of blanking the flag is sampled once, and the result drives an adaptive skip level.

The overcurrent flag arrives asynchronously from an analog comparator and is passed through a synchroniser before use. Each fault found at the end of blanking raises the skip level by one, and that many following turn-ons are then suppressed. The level saturates at its ceiling, so in a hard short the stage switches at a fraction of its nominal rate. Each clean end-of-blanking sample lowers the level by one. A fault that appears later in a pulse still ends that pulse, but it leaves the level unchanged.

Top module: `ocp_pulse_limiter`

## Requirements
- R1: Synchronous reset forces drive_out low and clears skip_count and limit_active. After reset, drive_out stays low until the first period_start strobe, and the first period after reset is always conducted.
- R2: On a conducted period, the comparator is ignored for BLANK_CYC cycles from the strobe. During that window drive_out follows pwm_req even when oc_raw is high.
- R3: If the synchronised flag is high when blanking ends, drive_out goes low and stays low for the rest of that period.
- R4: After blanking has ended, a later rise of oc_raw ends the pulse. The flag passes through SYNC_STAGES flops, so the pulse ends SYNC_STAGES+1 edges after oc_raw rises. skip_count is left unchanged.
- R5: A fault at the end of blanking raises skip_count by one. The next skip_count strobes are then skipped.
- R6: skip_count never exceeds SKIP_MAX. A fault at SKIP_MAX keeps the level at SKIP_MAX and again skips SKIP_MAX periods.
- R7: A clean end-of-blanking sample lowers skip_count by one, with a floor of zero.
- R8: In a skipped period, drive_out is low for the whole period, the comparator is not sampled, and skip_count does not change.
- R9: limit_active is high exactly when skip_count is non-zero or the current period's pulse has been cut.
- R10: In a conducted, uncut period, drive_out equals pwm_req, so a low request gives a low drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe at each switching-period turn-on |
| pwm_req | input | 1 | Raw on-request from the PWM |
| oc_raw | input | 1 | Asynchronous overcurrent comparator flag |
| drive_out | output | 1 | Gated gate-drive request |
| skip_count | output | LVL_W (3 at default) | Current adaptive skip level |
| limit_active | output | 1 | Current limiting in effect |

## Verification
The bench builds the limiter with a 4-cycle blanking window, a 2-flop synchroniser and a ceiling of 7, and it runs 16-cycle switching periods. With a window that short, one run can walk the skip level from zero to saturation and back, including a repeated fault at the ceiling. Each period is sampled inside blanking and again after the end-of-blanking decision. The short window also leaves room in each period for a late-fault cut, which lands a known number of edges after oc_raw rises.

// File: rtl/ocpl_pkg.sv
package ocpl_pkg;

    // Outcome of the period in progress.
    typedef enum logic [1:0] {
        PK_IDLE     = 2'd0,
        PK_SKIPPED  = 2'd1,
        PK_CONDUCT  = 2'd2,
        PK_CUT      = 2'd3
    } period_kind_e;

    // Bits needed to hold values 0..maxv.
    function automatic int unsigned width_for(input int unsigned maxv);
        return (maxv < 1) ? 1 : $clog2(maxv + 1);
    endfunction

    // Adaptive level step: up on fault (saturating), down when clean (floored).
    function automatic int unsigned next_level(input int unsigned cur,
                                               input logic        over,
                                               input int unsigned ceil);
        if (over)
            return (cur >= ceil) ? ceil : cur + 1;
        return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/ocpl_sync.sv
module ocpl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ocpl_blank_timer.sv
module ocpl_blank_timer
    import ocpl_pkg::*;
#(
    parameter int BLANK_CYC = 50,
    localparam int CW = width_for(BLANK_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic arm,
    output logic eval_now,
    output logic sense_open
);
    logic [CW-1:0] cnt_q;
    logic          blanking_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            blanking_q <= 1'b0;
        end else if (start) begin
            cnt_q      <= CW'(BLANK_CYC - 1);
            blanking_q <= arm;
        end else if (blanking_q) begin
            if (cnt_q == '0) blanking_q <= 1'b0;
            else             cnt_q      <= cnt_q - 1'b1;
        end
    end

    // Last blanking cycle: the single sampling point of the period.
    assign eval_now   = blanking_q && (cnt_q == '0) && !start;
    assign sense_open = !blanking_q && !start;

    // R2
    eval_single_chk: assert property (@(posedge clk) disable iff (rst)
        eval_now |=> !eval_now);
endmodule

// File: rtl/ocpl_skip_ctr.sv
module ocpl_skip_ctr
    import ocpl_pkg::*;
#(
    parameter int SKIP_MAX = 7,
    parameter int LVL_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_start,
    input  logic             eval_now,
    input  logic             over,
    output logic             skip_now,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] left_q;
    logic [LVL_W-1:0] lvl_n;

    always_comb begin
        lvl_n = LVL_W'(next_level(32'(lvl_q), over, SKIP_MAX));
    end

    assign skip_now = period_start && (left_q != '0);
    assign level    = lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            left_q <= '0;
        end else if (period_start) begin
            if (left_q != '0) left_q <= left_q - 1'b1;
        end else if (eval_now) begin
            lvl_q <= lvl_n;
            if (over) left_q <= lvl_n;
        end
    end

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(lvl_q) <= SKIP_MAX);

    // R7
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |->
            ((lvl_q == $past(lvl_q) + 1'b1) || (lvl_q + 1'b1 == $past(lvl_q))));

    // R8
    skip_budget_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= lvl_q);
endmodule

// File: rtl/ocp_pulse_limiter.sv
module ocp_pulse_limiter
    import ocpl_pkg::*;
#(
    parameter int  BLANK_CYC   = 50,
    parameter int  SKIP_MAX    = 7,
    parameter int  SYNC_STAGES = 2,
    localparam int LVL_W       = width_for(SKIP_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_start,
    input  logic             pwm_req,
    input  logic             oc_raw,
    output logic             drive_out,
    output logic [LVL_W-1:0] skip_count,
    output logic             limit_active
);
    logic         oc_sync;
    logic         skip_now;
    logic         eval_now;
    logic         sense_open;
    period_kind_e kind_q;

    ocpl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (oc_raw),
        .q   (oc_sync)
    );

    ocpl_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk        (clk),
        .rst        (rst),
        .start      (period_start),
        .arm        (!skip_now),
        .eval_now   (eval_now),
        .sense_open (sense_open)
    );

    ocpl_skip_ctr #(.SKIP_MAX(SKIP_MAX), .LVL_W(LVL_W)) u_skip (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .eval_now     (eval_now),
        .over         (oc_sync),
        .skip_now     (skip_now),
        .level        (skip_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= PK_IDLE;
        end else if (period_start) begin
            kind_q <= skip_now ? PK_SKIPPED : PK_CONDUCT;
        end else if (kind_q == PK_CONDUCT && (eval_now || sense_open) && oc_sync) begin
            kind_q <= PK_CUT;
        end
    end

    assign drive_out    = pwm_req && (kind_q == PK_CONDUCT);
    assign limit_active = (skip_count != '0) || (kind_q == PK_CUT);

    // R8
    skip_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
        skip_now |=> !drive_out);

    // R5
    rise_needs_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (skip_count > $past(skip_count)) |-> (kind_q == PK_CUT));

    // R3
    cut_drive_low_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_q == PK_CUT) |-> (!drive_out && limit_active));
endmodule

// File: tb/sim_ocp_pulse_limiter.sv
module sim_ocp_pulse_limiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_start = 1'b0;
    logic       pwm_req = 1'b0;
    logic       oc_raw = 1'b0;
    logic       drive_out;
    logic [2:0] skip_count;
    logic       limit_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ocp_pulse_limiter #(.BLANK_CYC(4), .SKIP_MAX(7), .SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .pwm_req      (pwm_req),
        .oc_raw       (oc_raw),
        .drive_out    (drive_out),
        .skip_count   (skip_count),
        .limit_active (limit_active)
    );

    // Per-period vector: bit5 = oc held, bits4:3 = kind (0 skipped, 1 full, 2 cut),
    // bits2:0 = skip level expected at the end of the period.
    localparam int NV = 60;
    localparam logic [5:0] VEC [NV] = '{
        6'd8,  6'd49, 6'd33, 6'd50, 6'd2,  6'd34,
        6'd51, 6'd35, 6'd3,  6'd35, 6'd52, 6'd36,
        6'd4,  6'd36, 6'd36, 6'd53, 6'd37, 6'd37,
        6'd5,  6'd37, 6'd37, 6'd54, 6'd38, 6'd38,
        6'd38, 6'd6,  6'd38, 6'd38, 6'd55, 6'd39,
        6'd39, 6'd7,  6'd39, 6'd39, 6'd39, 6'd39,
        6'd55, 6'd39, 6'd39, 6'd39, 6'd39, 6'd39,
        6'd39, 6'd7,  6'd14, 6'd13, 6'd54, 6'd38,
        6'd38, 6'd38, 6'd38, 6'd38, 6'd6,  6'd13,
        6'd12, 6'd11, 6'd10, 6'd9,  6'd8,  6'd8
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe at the next edge; returns just after that edge (E0).
    task automatic strobe(input logic oc, input logic req);
        @(negedge clk);
        period_start = 1'b1;
        pwm_req      = req;
        oc_raw       = oc;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1: watchdog act=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state with the request already high.
        pwm_req = 1'b1;
        wait_neg(3);
        rst = 1'b0;
        wait_neg(2);
        chk("R1 drive after reset", int'(drive_out), 0);
        chk("R1 level after reset", int'(skip_count), 0);
        chk("R1 limit after reset", int'(limit_active), 0);

        // Table walk, 16-cycle periods.
        for (int i = 0; i < NV; i++) begin
            logic       oc;
            logic [1:0] kd;
            logic [2:0] lv;
            oc = VEC[i][5];
            kd = VEC[i][4:3];
            lv = VEC[i][2:0];
            strobe(oc, 1'b1);
            wait_neg(1);   // after E1: inside blanking
            chk(kd == 2'd0 ? "R8 skipped drive mid" : "R2 blanking drive",
                int'(drive_out), (kd != 2'd0) ? 1 : 0);
            wait_neg(5);   // after E6: decision taken
            chk(kd == 2'd2 ? "R3 cut drive" : (kd == 2'd0 ? "R8 skipped drive" : "R10 full drive"),
                int'(drive_out), (kd == 2'd1) ? 1 : 0);
            wait_neg(8);   // after E14
            chk("R5/R6/R7 skip level", int'(skip_count), int'(lv));
            chk("R9 limit flag", int'(limit_active), (lv != 0 || kd == 2'd2) ? 1 : 0);
        end

        // Late fault after blanking: cut, level unchanged.
        strobe(1'b0, 1'b1);
        wait_neg(6);
        chk("R4 drive before late fault", int'(drive_out), 1);
        oc_raw = 1'b1;
        wait_neg(4);
        chk("R4 late cut drive", int'(drive_out), 0);
        chk("R4 late cut level", int'(skip_count), 0);
        chk("R9 late cut limit", int'(limit_active), 1);
        oc_raw = 1'b0;
        wait_neg(4);

        // Clean period after: cut cleared.
        strobe(1'b0, 1'b1);
        wait_neg(6);
        chk("R9 limit cleared", int'(limit_active), 0);
        wait_neg(8);

        // Request low gives low drive; drive follows request.
        strobe(1'b0, 1'b0);
        wait_neg(6);
        chk("R10 request low", int'(drive_out), 0);
        pwm_req = 1'b1;
        wait_neg(1);
        chk("R10 request high", int'(drive_out), 1);
        wait_neg(7);

        // Reset while skips are pending.
        strobe(1'b1, 1'b1);
        wait_neg(6);
        chk("R5 level before reset", int'(skip_count), 1);
        wait_neg(8);
        rst = 1'b1;
        wait_neg(2);
        rst = 1'b0;
        oc_raw = 1'b0;
        wait_neg(1);
        chk("R1 drive after mid reset", int'(drive_out), 0);
        chk("R1 level after mid reset", int'(skip_count), 0);
        chk("R1 limit after mid reset", int'(limit_active), 0);
        strobe(1'b0, 1'b1);
        wait_neg(1);
        chk("R1 first period conducted", int'(drive_out), 1);
        wait_neg(14);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule